// File: doc/BRIEF.md
# FIFO-Fed Asynchronous Serial Transmitter with Frame-Count Halt

This block turns bytes written by a host into asynchronous serial frames on a single output line. Bytes are queued in a 64-entry FIFO. Each frame carries a low start bit, 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit and one or two high stop bits. While the FIFO still holds data, frames follow one another with no idle time between them. When the FIFO runs dry, the line rests high.

Bit timing comes from an external baud-tick pulse, and every bit lasts 16 ticks. The next frame is chosen when the final stop bit begins: the transmitter either commits to another byte or raises a transmit-done flag. A fill-level flag rises whenever the FIFO holds fewer bytes than a selectable trigger level. An optional frame counter stops transmission after a programmed number of frames and raises a halt flag. The fill-level flag and the halt flag each have an enable, and both feed one shared interrupt output.

The host uses a write-only register port. Address 0 pushes a byte, address 1 sets the frame format, address 2 holds the trigger code and the interrupt enables, address 3 clears status flags, and address 4 holds the frame-count limit. The flags are also driven out directly as outputs.

Top module: `uart_fifo_tx`

## Requirements
- R1: After reset, `txd` is 1, `flag_low` and `flag_done` are 1, `flag_halt`, `flag_ovf` and `irq` are 0, `fifo_level` is 0, the format is 8 data bits with no parity and one stop bit, and the trigger code is 3.
- R2: A frame starts with one 0 bit followed by the data bits, least significant first. There are 8 data bits, or 7 when format bit 0 (address 1) is 1. Every bit lasts exactly 16 `baud_tick` pulses.
- R3: When format bit 1 is 1, a parity bit follows the data. The parity bit is the XOR of the data bits sent when format bit 2 is 0 (even parity), and its inverse when format bit 2 is 1 (odd parity).
- R4: A frame ends with one stop bit of value 1, or with two when format bit 3 is 1.
- R5: When another byte is available as the final stop bit ends, the next start bit begins on that same cycle. With no frame in progress, `txd` is 1.
- R6: The FIFO holds 64 bytes and `fifo_level` reports how many it holds. A byte written while the FIFO is full is dropped, and `flag_ovf` (status bit 3) is set and stays set.
- R7: `flag_low` (status bit 0) is set on every cycle in which `fifo_level` is below the trigger level. The trigger code sits in address 2 bits [2:0] and maps 0→0, 1→2, 2→4, 3→8, 4→16, 5 to 7→32.
- R8: `flag_done` (status bit 1) is set when the final stop bit of a frame begins and no further byte may be sent. It is cleared when a new frame is loaded, or when software clears it.
- R9: With a nonzero limit N in address 4, the transmitter stops loading bytes after N frames counted since the last restart. It sets `flag_halt` (status bit 2) when the Nth frame's final stop bit begins, and any remaining bytes stay in the FIFO. A limit of 0 disables this function, but a halt flag that is already set still holds transmission.
- R10: Clearing `flag_halt` while it is set restarts the frame count from zero and resumes transmission. Writing address 4 also restarts the count.
- R11: `irq` equals (address 2 bit 3 AND `flag_low`) OR (address 2 bit 4 AND `flag_halt`).
- R12: A write to address 3 clears each flag whose bit is written 0 and leaves each flag whose bit is written 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse; 16 pulses make one bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 data, 1 format, 2 control, 3 status clear, 4 frame limit) |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Combined interrupt request |
| flag_low | output | 1 | FIFO level below trigger |
| flag_done | output | 1 | Transmission ended with nothing left to send |
| flag_halt | output | 1 | Frame-count limit reached |
| flag_ovf | output | 1 | Sticky FIFO overflow |
| fifo_level | output | 7 | Number of bytes held in the FIFO |

## Verification
The hardest state to reach is a completely full FIFO, because the transmitter drains it continuously. The stimulus first sets a frame limit of 2 and writes three bytes. After the halt flag freezes the queue with one byte still held, it writes 63 more bytes and then one extra, which must be dropped. It then clears the limit, shows that the raised halt flag alone still holds the line idle, and releases the halt so that all 64 queued bytes can be compared frame by frame. A second run with a limit of 1 shows that the count restarts after the halt is cleared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_FMT  = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_STAT = 3'd3;
    localparam logic [2:0] ADDR_STOP = 3'd4;

    typedef struct packed {
        logic seven;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_fmt_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP_A,
        TX_STOP_Z
    } tx_state_t;

    // trigger code to fill level: 0 -> 0, n -> 2^n, capped at 32
    function automatic logic [7:0] trig_level(input logic [2:0] code);
        logic [7:0] lvl;
        if (code == 3'd0)
            lvl = 8'd0;
        else if (code >= 3'd5)
            lvl = 8'd32;
        else
            lvl = 8'd1 << code;
        return lvl;
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         drop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic full, push_ok, pop_ok;
    logic [PTR_W-1:0] wr_nxt, rd_nxt;

    assign full    = (st_q.level == LVL_W'(DEPTH));
    assign empty   = (st_q.level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign drop    = push && full;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_nxt = st_q.wr_ptr + 1'b1;
            assign rd_nxt = st_q.rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (st_q.wr_ptr == PTR_W'(DEPTH-1)) ? '0 : st_q.wr_ptr + 1'b1;
            assign rd_nxt = (st_q.rd_ptr == PTR_W'(DEPTH-1)) ? '0 : st_q.rd_ptr + 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wr_ptr = wr_nxt;
        if (pop_ok)  st_d.rd_ptr = rd_nxt;
        case ({push_ok, pop_ok})
            2'b10:   st_d.level = st_q.level + 1'b1;
            2'b01:   st_d.level = st_q.level - 1'b1;
            default: st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr_ptr] <= wdata;
    end

    assign rdata = mem[st_q.rd_ptr];
    assign level = st_q.level;

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              can_load,
    input  logic [DATA_W-1:0] load_data,
    input  frame_fmt_t        fmt_in,
    output logic              pop,
    output logic              stop_due,
    output logic              busy,
    output logic              txd
);
    localparam int TICK_W = $clog2(OVS);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef struct packed {
        tx_state_t         state;
        logic [TICK_W-1:0] tick;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              par;
        frame_fmt_t        fmt;
        logic              txd;
    } fr_t;

    fr_t d, q;
    logic bit_done, start_frame, enter_stop, par_n;
    logic [IDX_W-1:0] last_idx;

    assign bit_done = baud_tick && (q.tick == TICK_W'(OVS-1));
    assign last_idx = q.fmt.seven ? IDX_W'(DATA_W-2) : IDX_W'(DATA_W-1);
    assign par_n    = q.par ^ q.shreg[0];

    always_comb begin
        d           = q;
        pop         = 1'b0;
        stop_due    = 1'b0;
        start_frame = 1'b0;
        enter_stop  = 1'b0;

        if (q.state != TX_IDLE && baud_tick)
            d.tick = bit_done ? '0 : q.tick + 1'b1;

        case (q.state)
            TX_IDLE: begin
                d.txd = 1'b1;
                if (can_load) start_frame = 1'b1;
            end
            TX_START: begin
                if (bit_done) begin
                    d.state = TX_DATA;
                    d.idx   = '0;
                    d.txd   = q.shreg[0];
                end
            end
            TX_DATA: begin
                if (bit_done) begin
                    d.par   = par_n;
                    d.shreg = q.shreg >> 1;
                    if (q.idx == last_idx) begin
                        if (q.fmt.par_en) begin
                            d.state = TX_PARITY;
                            d.txd   = par_n ^ q.fmt.par_odd;
                        end else begin
                            enter_stop = 1'b1;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.txd = q.shreg[1];
                    end
                end
            end
            TX_PARITY: begin
                if (bit_done) enter_stop = 1'b1;
            end
            TX_STOP_A: begin
                if (bit_done) begin
                    d.state  = TX_STOP_Z;
                    stop_due = 1'b1;
                end
            end
            TX_STOP_Z: begin
                if (bit_done) begin
                    if (can_load) start_frame = 1'b1;
                    else          d.state = TX_IDLE;
                end
            end
            default: d.state = TX_IDLE;
        endcase

        if (enter_stop) begin
            d.txd = 1'b1;
            if (q.fmt.stop2) begin
                d.state = TX_STOP_A;
            end else begin
                d.state  = TX_STOP_Z;
                stop_due = 1'b1;
            end
        end

        if (start_frame) begin
            pop     = 1'b1;
            d.state = TX_START;
            d.shreg = load_data;
            d.fmt   = fmt_in;
            d.par   = 1'b0;
            d.tick  = '0;
            d.idx   = '0;
            d.txd   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != TX_IDLE);
    assign txd  = q.txd;

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input  logic                       fifo_empty,
    input  logic                       push_drop,
    input  logic                       frame_load,
    input  logic                       stop_due,
    output frame_fmt_t                 fmt,
    output logic                       can_load,
    output logic                       flag_low,
    output logic                       flag_done,
    output logic                       flag_halt,
    output logic                       flag_ovf,
    output logic                       irq,
    output logic [CNT_W-1:0]           stop_cnt
);
    localparam int LVL_W = $clog2(DEPTH+1);

    typedef struct packed {
        frame_fmt_t       fmt;
        logic [2:0]       trig_sel;
        logic             ien_low;
        logic             ien_halt;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] frames;
        logic             low;
        logic             done;
        logic             halt;
        logic             ovf;
    } ctrl_t;

    ctrl_t d, q;
    logic count_hit;
    logic [LVL_W-1:0] trig;

    assign count_hit = (q.limit != '0) && (q.frames == q.limit);
    assign can_load  = !fifo_empty && !q.halt && !count_hit;
    assign trig      = LVL_W'(trig_level(q.trig_sel));

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_FMT: begin
                    d.fmt.seven   = wr_data[0];
                    d.fmt.par_en  = wr_data[1];
                    d.fmt.par_odd = wr_data[2];
                    d.fmt.stop2   = wr_data[3];
                end
                ADDR_CTRL: begin
                    d.trig_sel = wr_data[2:0];
                    d.ien_low  = wr_data[3];
                    d.ien_halt = wr_data[4];
                end
                ADDR_STAT: begin
                    if (!wr_data[0]) d.low  = 1'b0;
                    if (!wr_data[1]) d.done = 1'b0;
                    if (!wr_data[2]) begin
                        if (q.halt) d.frames = '0;
                        d.halt = 1'b0;
                    end
                    if (!wr_data[3]) d.ovf = 1'b0;
                end
                ADDR_STOP: begin
                    d.limit  = wr_data[CNT_W-1:0];
                    d.frames = '0;
                end
                default: ;
            endcase
        end
        if (frame_load) begin
            d.frames = d.frames + 1'b1;
            d.done   = 1'b0;
        end
        if (stop_due) begin
            if (!can_load) d.done = 1'b1;
            if (count_hit) d.halt = 1'b1;
        end
        if (fifo_level < trig) d.low = 1'b1;
        if (push_drop)         d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.trig_sel <= 3'd3;
            q.low      <= 1'b1;
            q.done     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign fmt       = q.fmt;
    assign flag_low  = q.low;
    assign flag_done = q.done;
    assign flag_halt = q.halt;
    assign flag_ovf  = q.ovf;
    assign irq       = (q.ien_low & q.low) | (q.ien_halt & q.halt);
    assign stop_cnt  = q.limit;

endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int CNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       baud_tick,
    input  logic                       wr_en,
    input  logic [2:0]                 wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       txd,
    output logic                       irq,
    output logic                       flag_low,
    output logic                       flag_done,
    output logic                       flag_halt,
    output logic                       flag_ovf,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    frame_fmt_t        fmt;
    logic              can_load, pop, stop_due, tx_busy;
    logic              fifo_empty, push_drop, push;
    logic [DATA_W-1:0] fifo_rdata;
    logic [CNT_W-1:0]  stop_cnt;

    assign push = wr_en && (wr_addr == ADDR_DATA);

    uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (wr_data),
        .pop   (pop),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .empty (fifo_empty),
        .drop  (push_drop)
    );

    uart_tx_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fifo_level (fifo_level),
        .fifo_empty (fifo_empty),
        .push_drop  (push_drop),
        .frame_load (pop),
        .stop_due   (stop_due),
        .fmt        (fmt),
        .can_load   (can_load),
        .flag_low   (flag_low),
        .flag_done  (flag_done),
        .flag_halt  (flag_halt),
        .flag_ovf   (flag_ovf),
        .irq        (irq),
        .stop_cnt   (stop_cnt)
    );

    uart_tx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .can_load  (can_load),
        .load_data (fifo_rdata),
        .fmt_in    (fmt),
        .pop       (pop),
        .stop_due  (stop_due),
        .busy      (tx_busy),
        .txd       (txd)
    );

endmodule

// File: rtl/uart_fifo_tx_chk.sv
module uart_fifo_tx_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [2:0]                 wr_addr,
    input logic                       txd,
    input logic                       irq,
    input logic                       flag_low,
    input logic                       flag_halt,
    input logic                       flag_ovf,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic                       busy,
    input logic [CNT_W-1:0]           stop_cnt
);
    localparam int LVL_W = $clog2(DEPTH+1);

    assert_level_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && fifo_level == LVL_W'(DEPTH)) |=> flag_ovf);

    assert_level_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == $past(fifo_level)) || (fifo_level == $past(fifo_level) + 1'b1)
        || (fifo_level == $past(fifo_level) - 1'b1));

    assert_mark_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_low || flag_halt));

    assert_halt_needs_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_halt) |-> ($past(stop_cnt) != '0));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_halt && !busy && !(wr_en && wr_addr == 3'd3)) |=> !busy);

endmodule

bind uart_fifo_tx uart_fifo_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .txd        (txd),
    .irq        (irq),
    .flag_low   (flag_low),
    .flag_halt  (flag_halt),
    .flag_ovf   (flag_ovf),
    .fifo_level (fifo_level),
    .busy       (tx_busy),
    .stop_cnt   (stop_cnt)
);

// File: tb/uart_fifo_tx_tb.sv
module uart_fifo_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       txd, irq, flag_low, flag_done, flag_halt, flag_ovf;
    logic [6:0] fifo_level;

    int checks = 0;
    int errors = 0;
    int pending = 0;
    int b2b = 0;

    typedef struct {
        logic [7:0] data;
        bit seven;
        bit par_en;
        bit odd;
        bit stop2;
    } exp_t;

    exp_t exp_q[$];
    bit cur_seven = 0, cur_par = 0, cur_odd = 0, cur_stop2 = 0;

    always #2 clk = ~clk;

    uart_fifo_tx u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .txd(txd), .irq(irq), .flag_low(flag_low), .flag_done(flag_done),
        .flag_halt(flag_halt), .flag_ovf(flag_ovf), .fifo_level(fifo_level)
    );

    initial begin : tick_gen
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (!baud_tick);
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_fmt(input bit s7, input bit pe, input bit od, input bit s2);
        cur_seven = s7; cur_par = pe; cur_odd = od; cur_stop2 = s2;
        wr(3'd1, {4'b0, s2, od, pe, s7});
    endtask

    task automatic send(input logic [7:0] b);
        exp_t it;
        it.data = b; it.seven = cur_seven; it.par_en = cur_par;
        it.odd = cur_odd; it.stop2 = cur_stop2;
        exp_q.push_back(it);
        pending++;
        wr(3'd0, b);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60000 && pending != 0; i++) @(negedge clk);
        check(pending == 0, req, pending, 0);
        wait_ticks(20);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: decodes frames on txd and compares against the scoreboard queue
    initial begin : monitor
        bit chained;
        exp_t it;
        logic [7:0] got;
        logic ones;
        int nb;
        chained = 0;
        wait (rst_n);
        forever begin
            if (!chained) begin
                @(negedge clk);
                while (txd !== 1'b0) @(negedge clk);
            end
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected frame", 1, 0);
                it.data = 0; it.seven = 0; it.par_en = 0; it.odd = 0; it.stop2 = 0;
            end else begin
                it = exp_q.pop_front();
            end
            wait_ticks(8);
            check(txd == 1'b0, "R2 start bit", txd, 0);
            nb = it.seven ? 7 : 8;
            got = '0; ones = 1'b0;
            for (int i = 0; i < nb; i++) begin
                wait_ticks(16);
                got[i] = txd;
                ones ^= txd;
            end
            check(got == (it.seven ? (it.data & 8'h7F) : it.data), "R2 data bits",
                  got, it.seven ? (it.data & 8'h7F) : it.data);
            if (it.par_en) begin
                wait_ticks(16);
                check(txd == (ones ^ it.odd), "R3 parity bit", txd, ones ^ it.odd);
            end
            for (int s = 0; s < (it.stop2 ? 2 : 1); s++) begin
                wait_ticks(16);
                check(txd == 1'b1, "R4 stop bit", txd, 1);
            end
            pending--;
            wait_ticks(8);
            chained = (txd == 1'b0);
            if (chained) b2b++;
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        summary();
        $finish;
    end

    initial begin : main
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(flag_low == 1'b1, "R1 flag_low", flag_low, 1);
        check(flag_done == 1'b1, "R1 flag_done", flag_done, 1);
        check(flag_halt == 1'b0, "R1 flag_halt", flag_halt, 0);
        check(flag_ovf == 1'b0, "R1 flag_ovf", flag_ovf, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(fifo_level == 0, "R1 fifo_level", fifo_level, 0);

        // R12: clear only the done flag
        wr(3'd3, 8'hFD);
        check(flag_done == 1'b0, "R12 done cleared", flag_done, 0);
        check(flag_low == 1'b1, "R12 low kept", flag_low, 1);

        // R2 R5: default 8N1, back-to-back
        base = b2b;
        send(8'hA5); send(8'h3C); send(8'h01);
        drain("R2 8N1 drained");
        check(b2b - base == 2, "R5 no gap between frames", b2b - base, 2);
        check(flag_done == 1'b1, "R8 done after last frame", flag_done, 1);
        check(txd == 1'b1, "R5 mark when idle", txd, 1);

        // R3: 7 data bits, even parity
        set_fmt(1, 1, 0, 0);
        base = b2b;
        send(8'h55);
        @(negedge clk);
        check(flag_done == 1'b0, "R8 done cleared on load", flag_done, 0);
        send(8'h7F); send(8'h80);
        drain("R3 even parity drained");
        check(b2b - base == 2, "R5 gap with parity", b2b - base, 2);

        // R4: 8 bits, odd parity, two stop bits
        set_fmt(0, 1, 1, 1);
        base = b2b;
        send(8'h00); send(8'hFF); send(8'h96);
        drain("R4 two stop drained");
        check(b2b - base == 2, "R5 gap with two stops", b2b - base, 2);

        // R7 R11: trigger 8, low-level interrupt enabled
        set_fmt(0, 0, 0, 0);
        wr(3'd2, 8'h0B);
        check(irq == 1'b1, "R11 irq from low flag", irq, 1);
        for (int i = 0; i < 12; i++) send(8'(8'h40 + i));
        check(fifo_level == 11, "R6 level count", fifo_level, 11);
        wr(3'd3, 8'hFE);
        check(flag_low == 1'b0, "R7 low cleared at level 11", flag_low, 0);
        check(irq == 1'b0, "R11 irq drops", irq, 0);
        for (int i = 0; i < 20000 && !flag_low; i++) @(negedge clk);
        @(negedge clk);
        check(flag_low == 1'b1, "R7 low rises", flag_low, 1);
        check(fifo_level == 7, "R7 level below trigger", fifo_level, 7);
        check(irq == 1'b1, "R11 irq on low", irq, 1);
        drain("R7 drained");

        // R9 R6: halt after 2 frames, then fill FIFO
        wr(3'd2, 8'h13);
        check(irq == 1'b0, "R11 low masked", irq, 0);
        wr(3'd4, 8'd2);
        send(8'hC1); send(8'hC2); send(8'hC3);
        for (int i = 0; i < 20000 && !flag_halt; i++) @(negedge clk);
        check(flag_halt == 1'b1, "R9 halt set", flag_halt, 1);
        wait_ticks(48);
        check(txd == 1'b1, "R9 line idle while halted", txd, 1);
        check(fifo_level == 1, "R9 byte left in FIFO", fifo_level, 1);
        check(pending == 1, "R9 two frames sent", pending, 1);
        check(irq == 1'b1, "R11 irq on halt", irq, 1);
        for (int i = 0; i < 63; i++) send(8'(i * 3 + 1));
        check(fifo_level == 64, "R6 full", fifo_level, 64);
        wr(3'd0, 8'hEE);
        check(flag_ovf == 1'b1, "R6 overflow flag", flag_ovf, 1);
        check(fifo_level == 64, "R6 dropped write", fifo_level, 64);
        wr(3'd4, 8'd0);
        wait_ticks(40);
        check(fifo_level == 64, "R9 halt flag still holds", fifo_level, 64);
        wr(3'd3, 8'hFB);
        check(flag_halt == 1'b0, "R12 halt cleared", flag_halt, 0);
        drain("R10 resume drains full FIFO");
        check(flag_ovf == 1'b1, "R6 overflow sticky", flag_ovf, 1);
        wr(3'd3, 8'hF7);
        check(flag_ovf == 1'b0, "R12 overflow cleared", flag_ovf, 0);

        // R10: limit 1, count restarts on halt clear
        wr(3'd4, 8'd1);
        send(8'h11); send(8'h22);
        for (int i = 0; i < 20000 && !flag_halt; i++) @(negedge clk);
        wait_ticks(20);
        check(pending == 1, "R10 first halt after one frame", pending, 1);
        wr(3'd3, 8'hFB);
        drain("R10 second frame after clear");
        check(flag_halt == 1'b1, "R10 halt again after one more frame", flag_halt, 1);
        wr(3'd3, 8'hFB);
        wr(3'd4, 8'd0);

        // R7: trigger code 0 never sets, code 5 sets at level 0
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hFE);
        repeat (10) @(negedge clk);
        check(flag_low == 1'b0, "R7 trigger 0", flag_low, 0);
        wr(3'd2, 8'h05);
        @(negedge clk);
        check(flag_low == 1'b1, "R7 trigger 32", flag_low, 1);

        summary();
        $finish;
    end

endmodule